// File: doc/BRIEF.md
# Programmable Threshold Switch with Power-On State

This block turns a stream of signed field samples into a single switch output with hysteresis. The operate threshold is a base offset plus a signed code times a fixed step. The code is a 7-bit magnitude and a sign bit, so it spans −127 to +127. The release threshold is always a fixed hysteresis below the operate threshold, whatever the code. The output goes low when the field reaches the operate threshold, as when a tooth passes. It goes high again when the field falls below the release threshold, as in a valley or with no target. The sign bit only moves the threshold range. It never inverts the sense of the output.

After reset the output sits high and a validity timer starts counting clock cycles. Until the timer expires, the output stays high and sample strobes are ignored. The valid flag then rises and stays high. From that point the output follows the strobed samples. The default timer length is 50 µs at a 100 MHz clock.

Top module: `thr_switch`

## Requirements
- R1: While reset is asserted, `out_o` is 1 (high) and `valid_o` is 0.
- R2: While `valid_o` is 0, `out_o` stays 1 even when a strobed sample lies above the operate threshold.
- R3: `valid_o` becomes 1 after exactly `VALID_CYCLES` rising clock edges following reset release. It then stays 1 until the next reset.
- R4: After valid, a strobe with sample ≥ operate threshold drives `out_o` to 0 on the next clock edge. A sample one below the threshold does not.
- R5: After valid, a strobe with sample < release threshold (operate − `HYST`) drives `out_o` to 1 on the next clock edge.
- R6: A strobed sample with release ≤ sample < operate leaves `out_o` unchanged.
- R7: `out_o` changes only in the cycle after a strobe (`sample_vld_i` = 1). Samples presented without a strobe have no effect.
- R8: The operate threshold is `BASE_OFS + c*STEP`, where c = +`code_mag_i` when `code_neg_i` = 0 and c = −`code_mag_i` when `code_neg_i` = 1. A magnitude of 0 gives the same threshold with either sign.
- R9: A negative code does not invert the output: a field at or above a negative-code threshold still drives `out_o` low.
- R10: The gap between operate and release is `HYST` at both ends of the code range (+127 and −127).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | FIELD_W | Signed field sample |
| sample_vld_i | input | 1 | Sample strobe |
| code_mag_i | input | CODE_W | Threshold code magnitude |
| code_neg_i | input | 1 | Threshold code sign (1 = negative) |
| out_o | output | 1 | Switch output, 1 = high (released) |
| valid_o | output | 1 | Output valid after the power-on delay |

## Verification
At a positive code, samples are driven at the operate threshold, one below it, at the release threshold and one below it. These separate a strict compare from a non-strict one and show that the band between the thresholds holds state. A negative code, a negatively signed zero and both ends of the code range check the signed threshold arithmetic. They also show that the output sense is unchanged and that the hysteresis is the same across the range. Samples held without a strobe, and above-threshold strobes before the valid flag rises, show that neither moves the output.

// File: rtl/thr_switch_pkg.sv
package thr_switch_pkg;
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;

  localparam int unsigned TH_GUARD = 3;
endpackage

// File: rtl/thr_calc.sv
module thr_calc #(
  parameter int unsigned CODE_W   = 7,
  parameter int unsigned TH_W     = 19,
  parameter int          BASE_OFS = 1000,
  parameter int          STEP     = 20,
  parameter int          HYST     = 60
) (
  input  logic [CODE_W-1:0]      code_mag_i,
  input  logic                   code_neg_i,
  output logic signed [TH_W-1:0] op_th_o,
  output logic signed [TH_W-1:0] rel_th_o
);
  int signed code_s;
  int signed op_full;
  int signed rel_full;

  always_comb begin
    code_s   = code_neg_i ? -int'(code_mag_i) : int'(code_mag_i);
    op_full  = BASE_OFS + code_s * STEP;
    rel_full = op_full - HYST;
    op_th_o  = TH_W'(op_full);
    rel_th_o = TH_W'(rel_full);
  end
endmodule

// File: rtl/por_timer.sv
module por_timer #(
  parameter int unsigned VALID_CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic valid_o
);
  localparam int unsigned CW = $clog2(VALID_CYCLES + 1);
  localparam logic [CW-1:0] CNT_END = CW'(VALID_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = (cnt_q == CNT_END);
endmodule

// File: rtl/hyst_latch.sv
module hyst_latch
  import thr_switch_pkg::*;
#(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned TH_W    = 19
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic signed [FIELD_W-1:0] sample_i,
  input  logic                      sample_vld_i,
  input  logic signed [TH_W-1:0]    op_th_i,
  input  logic signed [TH_W-1:0]    rel_th_i,
  output logic                      out_o
);
  lvl_e lvl_q;
  lvl_e lvl_d;
  logic signed [TH_W-1:0] smp_x;

  always_comb begin
    smp_x = TH_W'(sample_i);
    lvl_d = lvl_q;
    if (en_i && sample_vld_i) begin
      if (smp_x >= op_th_i)      lvl_d = LVL_LOW;
      else if (smp_x < rel_th_i) lvl_d = LVL_HIGH;
    end
  end

  // power-on state is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= LVL_HIGH;
    else         lvl_q <= lvl_d;
  end

  assign out_o = (lvl_q == LVL_HIGH);
endmodule

// File: rtl/thr_switch.sv
module thr_switch
  import thr_switch_pkg::*;
#(
  parameter int unsigned FIELD_W      = 16,
  parameter int unsigned CODE_W       = 7,
  parameter int          BASE_OFS     = 1000,
  parameter int          STEP         = 20,
  parameter int          HYST         = 60,
  parameter int unsigned VALID_CYCLES = 5000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic signed [FIELD_W-1:0] sample_i,
  input  logic                      sample_vld_i,
  input  logic [CODE_W-1:0]         code_mag_i,
  input  logic                      code_neg_i,
  output logic                      out_o,
  output logic                      valid_o
);
  localparam int unsigned TH_W = FIELD_W + TH_GUARD;

  logic signed [TH_W-1:0] op_th;
  logic signed [TH_W-1:0] rel_th;

  thr_calc #(
    .CODE_W(CODE_W), .TH_W(TH_W), .BASE_OFS(BASE_OFS), .STEP(STEP), .HYST(HYST)
  ) u_calc (
    .code_mag_i(code_mag_i),
    .code_neg_i(code_neg_i),
    .op_th_o   (op_th),
    .rel_th_o  (rel_th)
  );

  por_timer #(.VALID_CYCLES(VALID_CYCLES)) u_por (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_o(valid_o)
  );

  hyst_latch #(.FIELD_W(FIELD_W), .TH_W(TH_W)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (valid_o),
    .sample_i    (sample_i),
    .sample_vld_i(sample_vld_i),
    .op_th_i     (op_th),
    .rel_th_i    (rel_th),
    .out_o       (out_o)
  );
endmodule

// File: rtl/thr_switch_chk.sv
module thr_switch_chk #(
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned TH_W    = 19
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic signed [FIELD_W-1:0] sample_i,
  input logic                      sample_vld_i,
  input logic                      out_o,
  input logic                      valid_o,
  input logic signed [TH_W-1:0]    op_th,
  input logic signed [TH_W-1:0]    rel_th
);
  logic signed [TH_W-1:0] smp_x;
  assign smp_x = TH_W'(sample_i);

  AST_POR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> out_o); // R2

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R3

  AST_OPERATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sample_vld_i && (smp_x >= op_th)) |=> !out_o); // R4

  AST_RELEASE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sample_vld_i && (smp_x < rel_th)) |=> out_o); // R5

  AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> $stable(out_o)); // R7
endmodule

bind thr_switch thr_switch_chk #(.FIELD_W(FIELD_W), .TH_W(TH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .sample_vld_i(sample_vld_i),
  .out_o       (out_o),
  .valid_o     (valid_o),
  .op_th       (op_th),
  .rel_th      (rel_th)
);

// File: tb/thr_switch_tb.sv
module thr_switch_tb;
  localparam int FIELD_W = 16;
  localparam int CODE_W  = 7;
  localparam int BASE    = 1000;
  localparam int STEP_V  = 20;
  localparam int HYST_V  = 60;
  localparam int VCYC    = 40;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic signed [FIELD_W-1:0] sample = '0;
  logic                      strobe = 1'b0;
  logic [CODE_W-1:0]         mag = '0;
  logic                      neg = 1'b0;
  logic                      out;
  logic                      valid;

  int checks = 0;
  int errors = 0;
  bit reported = 0;
  bit ref_lvl = 1'b1;

  bit exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  thr_switch #(
    .FIELD_W(FIELD_W), .CODE_W(CODE_W), .BASE_OFS(BASE), .STEP(STEP_V),
    .HYST(HYST_V), .VALID_CYCLES(VCYC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_vld_i(strobe),
    .code_mag_i(mag), .code_neg_i(neg), .out_o(out), .valid_o(valid)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: one strobed sample, expected output pushed to the scoreboard
  task automatic drive(input int smp, input int m, input bit n, input string tag);
    int op;
    int rel;
    op  = BASE + (n ? -m : m) * STEP_V;
    rel = op - HYST_V;
    @(negedge clk);
    sample = FIELD_W'(smp);
    mag    = CODE_W'(m);
    neg    = n;
    strobe = 1'b1;
    if (smp >= op)      ref_lvl = 1'b0;
    else if (smp < rel) ref_lvl = 1'b1;
    @(posedge clk);
    #1;
    exp_q.push_back(ref_lvl);
    tag_q.push_back(tag);
    @(negedge clk);
    strobe = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      automatic bit e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, out, e);
    end
  end

  initial begin
    #(20000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end

  initial begin
    bit pre_ok;
    sample = 16'sd5000;
    strobe = 1'b1;
    #23;
    check("R1 out in reset", out, 1'b1);
    check("R1 valid in reset", valid, 1'b0);
    @(negedge clk);
    rst_n  = 1'b1;
    pre_ok = 1'b1;
    for (int k = 1; k <= VCYC - 1; k++) begin
      @(posedge clk);
      #1;
      if (out !== 1'b1) pre_ok = 1'b0;
    end
    check("R3 valid low one edge early", valid, 1'b0);
    check("R2 strobes ignored before valid", pre_ok, 1'b1);
    @(negedge clk);
    strobe = 1'b0;
    @(posedge clk);
    #1;
    check("R3 valid at VALID_CYCLES", valid, 1'b1);
    check("R2 out high at valid", out, 1'b1);

    // code +10: op 1200, rel 1140
    drive(1199, 10, 0, "R4 one below operate holds high");
    drive(1200, 10, 0, "R4 at operate goes low");
    drive(1140, 10, 0, "R6 at release holds low");
    drive(1170, 10, 0, "R6 in band holds low");
    drive(1139, 10, 0, "R5 below release goes high");
    drive(1150, 10, 0, "R6 in band holds high");
    drive(5000, 10, 0, "R4 far above goes low");

    // R7: unstrobed low sample has no effect
    @(negedge clk);
    sample = -16'sd5000;
    for (int k = 0; k < 5; k++) @(posedge clk);
    #1;
    check("R7 unstrobed sample ignored", out, 1'b0);
    drive(-5000, 10, 0, "R7 strobed sample takes effect");
    check("R3 valid stays high", valid, 1'b1);

    // negative code -25: op 500, rel 440
    drive(499, 25, 1, "R9 below negative operate holds high");
    drive(500, 25, 1, "R9 at negative operate goes low");
    drive(439, 25, 1, "R9 below negative release goes high");

    // zero code with either sign: op 1000
    drive(999, 0, 1, "R8 minus zero one below holds high");
    drive(1000, 0, 1, "R8 minus zero at operate goes low");
    drive(0, 0, 0, "R8 release");
    drive(1000, 0, 0, "R8 plus zero at operate goes low");

    // code +127: op 3540, rel 3480
    drive(3539, 127, 0, "R8 max code below holds low");
    drive(3479, 127, 0, "R10 max code below release high");
    drive(3539, 127, 0, "R10 max code band holds high");
    drive(3540, 127, 0, "R10 max code at operate low");
    drive(3480, 127, 0, "R10 max code at release holds low");

    // code -127: op -1540, rel -1600
    drive(-1601, 127, 1, "R10 min code below release high");
    drive(-1541, 127, 1, "R10 min code band holds high");
    drive(-1540, 127, 1, "R10 min code at operate low");
    drive(-1600, 127, 1, "R10 min code at release holds low");
    drive(-1601, 127, 1, "R10 min code below release high again");

    repeat (3) @(negedge clk);
    report();
  end
endmodule